// File: doc/BRIEF.md
# Unsigned Multiply-Accumulate Unit

This block is the multiply-accumulate datapath of a 16-bit DSP-style core. It holds a small bank of 40-bit accumulators (two by default). Each accepted operation multiplies two 16-bit operands, treated as unsigned, into a full 32-bit product. When the fractional-mode flag is set, the product is doubled. The selected accumulator is then overwritten with the product, has the product added to it, or has the product subtracted from it. Every result wraps modulo 2^40.

Operations arrive on a valid/ready stream. `op_ready` is the only back-pressure. It is low while reset is asserted and high in every other cycle. An operation takes effect on the clock edge where `op_valid` and `op_ready` are both high. The producer must hold its fields steady until that edge.

A separate load port writes a 40-bit value straight into one accumulator, for test setup. All accumulators can be read at all times on a flat read bus.

Top module: `mac_unit`

## Requirements
- R1: Both operands are zero-extended and the full 32-bit product is kept. For example, 0xFFFF times 0xFFFF gives 0xFFFE0001.
- R2: With `frac_mode` high, the product is shifted left by one bit before use, and the shift may carry into bit 32. For example, 0xFFFF times 0xFFFF gives 0x1_FFFC_0002.
- R3: `op_sel` 2'b00 (store) writes the product, zero-extended to 40 bits, into the selected accumulator.
- R4: `op_sel` 2'b01 (add) writes accumulator plus product, keeping the low 40 bits.
- R5: `op_sel` 2'b10 (subtract) writes accumulator minus product, keeping the low 40 bits, with no sign extension of the old value. For example, 0x7F_FFFF_FFFF minus 0x8001 times 0xFFFF gives 0x7F_7FFF_8000, or 0x7E_FFFF_0001 with `frac_mode` high.
- R6: `op_sel` 2'b11 is reserved. An accepted reserved operation leaves every accumulator unchanged.
- R7: An accumulator changes only on an edge where `op_valid` and `op_ready` are both high and `acc_idx` selects it, or where the load port targets it. The other accumulators hold their values.
- R8: With `ld_en` high, `ld_data` is written into accumulator `ld_idx` on the clock edge. If an accepted operation targets the same accumulator in the same cycle, the operation wins.
- R9: Synchronous reset clears all accumulators to zero. `op_ready` is low while `rst` is high.
- R10: Accumulator i appears on `acc_rd[40*i+39 : 40*i]`, updated one clock after the edge that wrote it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Operation can be taken (low during reset) |
| op_sel | input | 2 | 00 store, 01 add, 10 subtract, 11 reserved |
| acc_idx | input | 1 | Target accumulator of the operation |
| src_a | input | 16 | First unsigned operand |
| src_b | input | 16 | Second unsigned operand |
| frac_mode | input | 1 | Double the product when high |
| ld_en | input | 1 | Direct accumulator load strobe |
| ld_idx | input | 1 | Target accumulator of the load |
| ld_data | input | 40 | Load value |
| acc_rd | output | 80 | All accumulators, accumulator 0 in the low bits |

## Verification
The operand pairs are chosen to separate the different ways the arithmetic can go wrong. Operands with the top bit set, such as 0x8001 and 0xFFFF, show whether the operands are zero-extended or sign-extended. They also show whether the product is truncated to 16 bits. Pairing them with `frac_mode` set shows whether the doubling carries into bit 32.

Subtracting from 0x7F_FFFF_FFFF, and from a small value that underflows, separates a 40-bit wrap from a signed treatment of the old accumulator. Adding to an all-ones accumulator checks the wrap in the other direction.

Directed cases cover the remaining behaviour:
- an operation offered without `op_valid`;
- the reserved code;
- a load and an operation aimed at the same accumulator, and at different accumulators;
- an operation offered during reset.

// File: rtl/mac_pkg.sv
package mac_pkg;
  localparam int OPND_W = 16;
  localparam int PROD_W = 2 * OPND_W + 1;
  localparam int ACC_W  = 40;

  typedef enum logic [1:0] {
    OP_STORE = 2'b00,
    OP_ADD   = 2'b01,
    OP_SUB   = 2'b10,
    OP_RSVD  = 2'b11
  } mac_op_e;
endpackage

// File: rtl/mac_mult.sv
module mac_mult
  import mac_pkg::*;
#(
  parameter int W = OPND_W
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic           frac,
  output logic [2*W:0]   prod
);
  localparam int PW = 2 * W;
  logic [PW-1:0] raw;

  always_comb begin
    raw  = a * b;
    prod = frac ? {raw, 1'b0} : {1'b0, raw};
  end

  // R2
  no_carry_plain_chk: assert final (frac || !prod[PW]);
  // R2
  even_when_frac_chk: assert final (!frac || !prod[0]);
endmodule

// File: rtl/mac_combine.sv
module mac_combine
  import mac_pkg::*;
#(
  parameter int AW = ACC_W,
  parameter int PW = PROD_W
) (
  input  logic [1:0]    op,
  input  logic [AW-1:0] acc_in,
  input  logic [PW-1:0] prod,
  output logic [AW-1:0] acc_out
);
  logic [AW-1:0] prod_ext;

  always_comb begin
    prod_ext = AW'(prod);
    unique case (mac_op_e'(op))
      OP_STORE: acc_out = prod_ext;
      OP_ADD:   acc_out = acc_in + prod_ext;
      OP_SUB:   acc_out = acc_in - prod_ext;
      default:  acc_out = acc_in;
    endcase
  end
endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
#(
  parameter int NUM_ACC = 2,
  parameter int DW      = OPND_W,
  parameter int AW      = ACC_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  op_valid,
  output logic                  op_ready,
  input  logic [1:0]            op_sel,
  input  logic                  acc_idx,
  input  logic [DW-1:0]         src_a,
  input  logic [DW-1:0]         src_b,
  input  logic                  frac_mode,
  input  logic                  ld_en,
  input  logic                  ld_idx,
  input  logic [AW-1:0]         ld_data,
  output logic [NUM_ACC*AW-1:0] acc_rd
);
  localparam int PW = 2 * DW + 1;

  logic          fire;
  logic [PW-1:0] prod;
  logic [AW-1:0] acc_sel;
  logic [AW-1:0] acc_next;
  logic [AW-1:0] acc_q [NUM_ACC];

  assign op_ready = !rst;
  assign fire     = op_valid && op_ready;
  assign acc_sel  = acc_q[int'(acc_idx)];

  mac_mult #(.W(DW)) u_mult (
    .a(src_a), .b(src_b), .frac(frac_mode), .prod(prod)
  );

  mac_combine #(.AW(AW), .PW(PW)) u_comb (
    .op(op_sel), .acc_in(acc_sel), .prod(prod), .acc_out(acc_next)
  );

  for (genvar i = 0; i < NUM_ACC; i++) begin : g_acc
    logic op_hit, ld_hit;
    assign op_hit = fire && (int'(acc_idx) == i);
    assign ld_hit = ld_en && (int'(ld_idx) == i);

    always_ff @(posedge clk) begin
      if (rst)         acc_q[i] <= '0;
      else if (op_hit) acc_q[i] <= acc_next;
      else if (ld_hit) acc_q[i] <= ld_data;
    end

    assign acc_rd[i*AW +: AW] = acc_q[i];

    // R7
    hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !(op_valid && (int'(acc_idx) == i)) && !(ld_en && (int'(ld_idx) == i))
      |=> $stable(acc_rd[i*AW +: AW]));
    // R9
    reset_clear_chk: assert property (@(posedge clk)
      rst |=> (acc_rd[i*AW +: AW] == '0));
    // R3
    store_zext_chk: assert property (@(posedge clk) disable iff (rst)
      op_valid && (int'(acc_idx) == i) && (op_sel == 2'b00)
      |=> (acc_rd[i*AW + PW +: AW-PW] == '0));
    // R6
    rsvd_hold_chk: assert property (@(posedge clk) disable iff (rst)
      op_valid && (int'(acc_idx) == i) && (op_sel == 2'b11)
      |=> $stable(acc_rd[i*AW +: AW]));
  end
endmodule

// File: tb/mac_unit_test.sv
module mac_unit_test;
  localparam int AW = 40;

  logic clk = 0, rst = 1;
  logic op_valid = 0, op_ready, acc_idx = 0, frac_mode = 0, ld_en = 0, ld_idx = 0;
  logic [1:0]  op_sel = 0;
  logic [15:0] src_a = 0, src_b = 0;
  logic [AW-1:0] ld_data = 0;
  logic [2*AW-1:0] acc_rd;

  int checks = 0, errors = 0;
  logic [AW-1:0] known [2];

  always #4 clk = ~clk;

  mac_unit uut (.*);

  typedef struct packed {
    logic        idx;
    logic [1:0]  op;
    logic [15:0] a;
    logic [15:0] b;
    logic        frac;
    logic [39:0] pre;
    logic [39:0] exp;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{1'b0, 2'b10, 16'h8001, 16'hFFFF, 1'b0, 40'h7F_FFFF_FFFF, 40'h7F_7FFF_8000},
    '{1'b0, 2'b10, 16'h8001, 16'hFFFF, 1'b1, 40'h7F_FFFF_FFFF, 40'h7E_FFFF_0001},
    '{1'b1, 2'b00, 16'hFFFF, 16'hFFFF, 1'b0, 40'h12_3456_789A, 40'h00_FFFE_0001},
    '{1'b1, 2'b00, 16'hFFFF, 16'hFFFF, 1'b1, 40'h12_3456_789A, 40'h01_FFFC_0002},
    '{1'b0, 2'b01, 16'h0001, 16'h0001, 1'b0, 40'hFF_FFFF_FFFF, 40'h00_0000_0000},
    '{1'b0, 2'b10, 16'h0002, 16'h0010, 1'b0, 40'h00_0000_0010, 40'hFF_FFFF_FFF0},
    '{1'b1, 2'b01, 16'h8000, 16'h8000, 1'b1, 40'h00_0000_0005, 40'h00_8000_0005},
    '{1'b0, 2'b01, 16'h0000, 16'hFFFF, 1'b1, 40'h00_0000_000A, 40'h00_0000_000A},
    '{1'b1, 2'b11, 16'h1234, 16'h5678, 1'b0, 40'h00_0000_0033, 40'h00_0000_0033},
    '{1'b1, 2'b01, 16'hFFFF, 16'hFFFF, 1'b1, 40'hFE_0000_0000, 40'hFF_FFFC_0002}
  };

  task automatic check(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] rd(int i);
    return acc_rd[i*AW +: AW];
  endfunction

  task automatic load(logic idx, logic [AW-1:0] v);
    @(negedge clk);
    ld_en = 1; ld_idx = idx; ld_data = v;
    @(negedge clk);
    ld_en = 0;
    known[idx] = v;
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R9: reset state and ready low during reset, op offered is ignored
    @(negedge clk);
    op_valid = 1; op_sel = 2'b00; src_a = 16'h0003; src_b = 16'h0003;
    check("R9 ready in reset", {39'd0, op_ready}, 40'd0);
    @(negedge clk);
    check("R9 acc0 reset", rd(0), 40'd0);
    check("R9 acc1 reset", rd(1), 40'd0);
    op_valid = 0;
    rst = 0;
    @(negedge clk);
    check("R9 ready after reset", {39'd0, op_ready}, 40'd1);
    known[0] = 0; known[1] = 0;

    // Vector table: R1 R2 R3 R4 R5 R6 R7 R10
    foreach (VECS[k]) begin
      load(VECS[k].idx, VECS[k].pre);
      op_valid = 1; op_sel = VECS[k].op; acc_idx = VECS[k].idx;
      src_a = VECS[k].a; src_b = VECS[k].b; frac_mode = VECS[k].frac;
      @(negedge clk);
      op_valid = 0;
      check($sformatf("R1-5 vec %0d result", k), rd(int'(VECS[k].idx)), VECS[k].exp);
      check($sformatf("R7 vec %0d other acc", k), rd(int'(!VECS[k].idx)), known[!VECS[k].idx]);
      known[VECS[k].idx] = VECS[k].exp;
    end

    // R7: fields present but op_valid low -> no change
    op_valid = 0; op_sel = 2'b00; acc_idx = 0; src_a = 16'h1111; src_b = 16'h2222;
    @(negedge clk);
    check("R7 no valid acc0", rd(0), known[0]);
    check("R7 no valid acc1", rd(1), known[1]);

    // R8: load and op on the same accumulator, op wins
    load(0, 40'h00_0000_0100);
    op_valid = 1; op_sel = 2'b01; acc_idx = 0; src_a = 16'h0002; src_b = 16'h0003; frac_mode = 0;
    ld_en = 1; ld_idx = 0; ld_data = 40'hAA_AAAA_AAAA;
    @(negedge clk);
    op_valid = 0; ld_en = 0;
    check("R8 op wins same acc", rd(0), 40'h00_0000_0106);

    // R8: load and op on different accumulators both take effect
    op_valid = 1; op_sel = 2'b00; acc_idx = 1; src_a = 16'h0010; src_b = 16'h0010;
    ld_en = 1; ld_idx = 0; ld_data = 40'h55_5555_5555;
    @(negedge clk);
    op_valid = 0; ld_en = 0;
    check("R8 load other acc", rd(0), 40'h55_5555_5555);
    check("R3 store other acc", rd(1), 40'h00_0000_0100);

    // R9: reset clears loaded values
    rst = 1;
    @(negedge clk);
    check("R9 reclear acc0", rd(0), 40'd0);
    check("R9 reclear acc1", rd(1), 40'd0);
    rst = 0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule